// File: doc/BRIEF.md
# RTC Snapshot Write-Back Buffer

This block sits between a byte-level two-wire serial slave front end and a bank of real-time clock counters. When a write access opens, it captures every timekeeping counter byte into a local buffer. The first byte after the device address becomes the location of an auto-incrementing pointer. The data bytes that follow edit the buffer copy. The counters never take a byte directly. When the write ends, the block loads the entire buffer into the counters in one cycle, so any byte the master did not write goes back with its snapshot value. The write can end with a stop, with a repeated start, or with the pointer stepping past the last buffer slot.

The front end sends single-cycle event strobes: start, stop, device-address match (with its R/W bit) and byte received (with the byte). The block answers with an acknowledge request, a counter load strobe with the full load word, and a write strobe for the generic registers that sit above the buffer range.

Top module: `rtc_wb_top`

## Requirements
- R1: `ack_o` pulses one cycle after `addr_match_i`, for either R/W value. It also pulses one cycle after every `byte_valid_i` that arrives inside a write access. It never pulses for bytes received outside a write access.
- R2: In a write access, the first byte after the device address loads the pointer and is not stored as data.
- R3: `addr_match_i` with `rw_i`=0 captures all eight bytes of `cnt_i` from that same cycle into the buffer. Byte k is bits [8k+7:8k].
- R4: A data byte received while the pointer is in 00h..07h replaces buffer byte k = pointer. After each data byte the pointer increments by one.
- R5: A stop during a write access pulses `cnt_load_o` one cycle later. `cnt_load_data_o` then carries the buffer, with unwritten bytes equal to the snapshot.
- R6: A data byte written at pointer 07h pulses `cnt_load_o` one cycle later, and the load word already includes that byte.
- R7: At most one load happens per write access. A stop after an early load gives no further pulse, and bytes that land in 00h..07h after it are dropped.
- R8: A write access that ends after the word-address byte alone, or right after the device address, still loads the unchanged snapshot.
- R9: A data byte received while the pointer is above 07h pulses `reg_we_o` one cycle later, with `reg_addr_o` set to the pointer and `reg_wdata_o` set to the byte. The pointer wraps from FFh to 00h.
- R10: A start during a write access ends it exactly as a stop does, including the load.
- R11: During and right after reset every output is 0 and the block is idle.
- R12: A read access (`rw_i`=1) takes no snapshot and loads nothing. Its bytes cause no load and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated-start event |
| stop_i | input | 1 | Stop event |
| addr_match_i | input | 1 | Device address byte received and matched |
| rw_i | input | 1 | R/W bit, valid with addr_match_i (0 = write) |
| byte_valid_i | input | 1 | A byte after the device address was received |
| byte_data_i | input | 8 | Received byte |
| cnt_i | input | 64 | Live counter bank, byte k at [8k+7:8k] |
| ack_o | output | 1 | Acknowledge request |
| cnt_load_o | output | 1 | Load all counters from cnt_load_data_o |
| cnt_load_data_o | output | 64 | Buffer contents, byte k at [8k+7:8k] |
| reg_we_o | output | 1 | Generic register write strobe |
| reg_addr_o | output | 8 | Generic register address |
| reg_wdata_o | output | 8 | Generic register write data |

## Verification
The counter bank keeps incrementing, so a snapshot taken in the wrong cycle gives a different load word. A single-byte edit followed by a stop shows whether the other seven bytes come back unchanged. A write that runs from 05h past 07h and then ends with a stop separates the early load from the stop load and exposes any double commit. A write that starts at FEh checks the register port and the wrap into buffer slot 0. Repeated-start and read transactions tell the two ways a transaction can end from the cases where nothing should happen.

// File: rtl/rtc_wb_pkg.sv
package rtc_wb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WADDR = 2'd1,
    ST_WDATA = 2'd2
  } wb_state_e;
endpackage

// File: rtl/rtc_wb_bank.sv
module rtc_wb_bank #(
  parameter int NB = 8,
  parameter int IW = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            snap_i,
  input  logic [NB*8-1:0] cnt_i,
  input  logic            we_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [7:0]      wdata_i,
  output logic [NB*8-1:0] buf_o
);
  for (genvar k = 0; k < NB; k++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= '0;
      else if (snap_i) slot_q <= cnt_i[8*k +: 8];
      else if (we_i && (idx_i == IW'(k))) slot_q <= wdata_i;
    end
    assign buf_o[8*k +: 8] = slot_q;
  end

  // R3
  snap_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snap_i && we_i));
endmodule

// File: rtl/rtc_wb_ctrl.sv
module rtc_wb_ctrl
  import rtc_wb_pkg::*;
#(
  parameter int NB = 8,
  parameter int AW = 8,
  parameter int IW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_match_i,
  input  logic          rw_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_data_i,
  output logic          snap_o,
  output logic          buf_we_o,
  output logic [IW-1:0] buf_idx_o,
  output logic          ack_o,
  output logic          load_o,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o
);
  localparam logic [AW-1:0] LAST = AW'(NB - 1);

  wb_state_e     state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          done_q, done_d;
  logic          end_ev, data_ev, in_buf, reg_we, commit, in_write;

  assign in_write = (state_q != ST_IDLE);
  assign end_ev   = (stop_i | start_i) & in_write;
  assign data_ev  = byte_valid_i & (state_q == ST_WDATA) & ~end_ev & ~addr_match_i;
  assign in_buf   = (ptr_q <= LAST);
  assign snap_o   = addr_match_i & ~rw_i & ~end_ev;
  assign buf_we_o = data_ev & in_buf & ~done_q;
  assign buf_idx_o = ptr_q[IW-1:0];
  assign reg_we   = data_ev & ~in_buf;
  // end of access or pointer leaving the buffer range, once per access
  assign commit   = (end_ev & ~done_q) | (buf_we_o & (ptr_q == LAST));

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    done_d  = done_q | commit;
    if (end_ev) begin
      state_d = ST_IDLE;
    end else if (addr_match_i) begin
      state_d = rw_i ? ST_IDLE : ST_WADDR;
      if (!rw_i) done_d = 1'b0;
    end else if (byte_valid_i && state_q == ST_WADDR) begin
      ptr_d   = byte_data_i;
      state_d = ST_WDATA;
    end else if (data_ev) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ptr_q       <= '0;
      done_q      <= 1'b0;
      ack_o       <= 1'b0;
      load_o      <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      done_q   <= done_d;
      ack_o    <= addr_match_i | (byte_valid_i & in_write & ~end_ev);
      load_o   <= commit;
      reg_we_o <= reg_we;
      if (reg_we) begin
        reg_addr_o  <= ptr_q;
        reg_wdata_o <= byte_data_i;
      end
    end
  end

  // R5
  stop_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && in_write && !done_q) |=> load_o);
  // R7
  single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> done_q);
  // R12
  read_no_edit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !buf_we_o);
endmodule

// File: rtl/rtc_wb_top.sv
module rtc_wb_top #(
  parameter int NB = 8,
  parameter int AW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            addr_match_i,
  input  logic            rw_i,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_data_i,
  input  logic [NB*8-1:0] cnt_i,
  output logic            ack_o,
  output logic            cnt_load_o,
  output logic [NB*8-1:0] cnt_load_data_o,
  output logic            reg_we_o,
  output logic [AW-1:0]   reg_addr_o,
  output logic [7:0]      reg_wdata_o
);
  localparam int IW = $clog2(NB);
  localparam logic [AW-1:0] LAST = AW'(NB - 1);

  logic          snap, buf_we;
  logic [IW-1:0] buf_idx;

  rtc_wb_ctrl #(.NB(NB), .AW(AW), .IW(IW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .addr_match_i, .rw_i,
    .byte_valid_i, .byte_data_i,
    .snap_o(snap), .buf_we_o(buf_we), .buf_idx_o(buf_idx),
    .ack_o, .load_o(cnt_load_o),
    .reg_we_o, .reg_addr_o, .reg_wdata_o
  );

  rtc_wb_bank #(.NB(NB), .IW(IW)) u_bank (
    .clk_i, .rst_ni, .snap_i(snap), .cnt_i, .we_i(buf_we),
    .idx_i(buf_idx), .wdata_i(byte_data_i), .buf_o(cnt_load_data_o)
  );

  // R1
  addr_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_i |=> ack_o);
  // R9
  reg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_addr_o > LAST));
  // R7
  no_back_to_back_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load_o |=> !cnt_load_o);
endmodule

// File: tb/rtc_wb_top_tb.sv
module rtc_wb_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0, stop = 0, amatch = 0, rw = 0, bvalid = 0;
  logic [7:0]  bdata = 0;
  logic [63:0] cnt_v = 64'h0102_0304_0506_0700;
  logic        ack, ld, rwe;
  logic [63:0] ldata;
  logic [7:0]  raddr, rdata;

  int tests = 0, fails = 0;
  int load_cnt = 0, reg_cnt = 0;
  logic [63:0] last_ld = 0, snap = 0;
  logic [7:0]  last_raddr = 0, last_rdata = 0;

  always #2.5 clk = ~clk;

  rtc_wb_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .addr_match_i(amatch), .rw_i(rw), .byte_valid_i(bvalid), .byte_data_i(bdata),
    .cnt_i(cnt_v), .ack_o(ack), .cnt_load_o(ld), .cnt_load_data_o(ldata),
    .reg_we_o(rwe), .reg_addr_o(raddr), .reg_wdata_o(rdata)
  );

  // live counters: free-running, reloaded on commit
  always @(posedge clk) cnt_v <= ld ? ldata : cnt_v + 64'd1;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference
  byte unsigned mbuf[8];
  int  m_st = 0, m_ptr = 0;
  bit  m_done = 0;
  bit  e_ack = 0, e_ld = 0, e_rwe = 0;
  logic [63:0] e_ldata = 0;
  int  e_raddr = 0, e_rdata = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_done = 0; e_ack = 0; e_ld = 0; e_rwe = 0;
      e_raddr = 0; e_rdata = 0;
      foreach (mbuf[i]) mbuf[i] = 0;
    end else begin
      bit endv;
      endv  = (stop || start) && m_st != 0;
      e_ack = amatch || (bvalid && m_st != 0 && !endv);
      e_ld  = 0;
      e_rwe = 0;
      if (endv) begin
        if (!m_done) e_ld = 1;
        m_done = 1;
        m_st = 0;
      end else if (amatch) begin
        if (!rw) begin
          m_st = 1; m_done = 0;
          for (int i = 0; i < 8; i++) mbuf[i] = cnt_v[8*i +: 8];
        end else m_st = 0;
      end else if (bvalid && m_st == 1) begin
        m_ptr = bdata; m_st = 2;
      end else if (bvalid && m_st == 2) begin
        if (m_ptr < 8) begin
          if (!m_done) begin
            mbuf[m_ptr] = bdata;
            if (m_ptr == 7) begin e_ld = 1; m_done = 1; end
          end
        end else begin
          e_rwe = 1; e_raddr = m_ptr; e_rdata = bdata;
        end
        m_ptr = (m_ptr + 1) % 256;
      end
      for (int i = 0; i < 8; i++) e_ldata[8*i +: 8] = mbuf[i];
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) if (rst_n) begin
    check("R1 ack", 64'(ack), 64'(e_ack));
    check("R5 load strobe", 64'(ld), 64'(e_ld));
    if (e_ld) check("R4 load data", ldata, e_ldata);
    check("R9 reg strobe", 64'(rwe), 64'(e_rwe));
    if (e_rwe) begin
      check("R9 reg addr", 64'(raddr), 64'(e_raddr));
      check("R9 reg data", 64'(rdata), 64'(e_rdata));
    end
    if (ld) begin load_cnt++; last_ld = ldata; end
    if (rwe) begin reg_cnt++; last_raddr = raddr; last_rdata = rdata; end
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
    @(negedge clk);
  endtask
  task automatic dev_addr(bit r);
    @(negedge clk); rw = r; amatch = 1; snap = cnt_v;
    @(negedge clk); amatch = 0; rw = 0;
    @(negedge clk);
  endtask
  task automatic send(logic [7:0] d);
    @(negedge clk); bvalid = 1; bdata = d;
    @(negedge clk); bvalid = 0;
    @(negedge clk);
  endtask
  task automatic do_start(); pulse(start); endtask
  task automatic do_stop();  pulse(stop);  endtask
  function automatic logic [63:0] put(logic [63:0] v, int k, logic [7:0] b);
    logic [63:0] r = v;
    r[8*k +: 8] = b;
    return r;
  endfunction

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ack", 64'(ack), 0);
    check("R11 load", 64'(ld), 0);
    check("R11 load data", ldata, 0);
    check("R11 reg we", 64'(rwe), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R5: edit one byte, stop
    n0 = load_cnt;
    do_start(); dev_addr(0); send(8'h03); send(8'h22); do_stop();
    check("R5 one load", 64'(load_cnt - n0), 1);
    check("R3 snapshot kept", last_ld, put(snap, 3, 8'h22));

    // R8: word address only
    n0 = load_cnt;
    do_start(); dev_addr(0); send(8'h01); do_stop();
    check("R8 load count", 64'(load_cnt - n0), 1);
    check("R8 snapshot only", last_ld, snap);

    // R8: no word address at all
    n0 = load_cnt;
    do_start(); dev_addr(0); do_stop();
    check("R8 addr only load", last_ld, snap);

    // R6 R7 R9: 05..07 then 08, then stop
    n0 = load_cnt;
    do_start(); dev_addr(0); send(8'h05); send(8'hA5); send(8'hA6);
    send(8'hA7);
    check("R6 early load", 64'(load_cnt - n0), 1);
    check("R6 early data", last_ld, put(put(put(snap, 5, 8'hA5), 6, 8'hA6), 7, 8'hA7));
    send(8'h5C);
    check("R9 reg addr 08", 64'(last_raddr), 64'h08);
    do_stop();
    check("R7 no second load", 64'(load_cnt - n0), 1);

    // R9 wrap FE, FF, 00
    n0 = load_cnt;
    do_start(); dev_addr(0); send(8'hFE); send(8'h11); send(8'h12);
    check("R9 reg addr FF", 64'(last_raddr), 64'hFF);
    send(8'h13); do_stop();
    check("R9 wrap into slot 0", last_ld, put(snap, 0, 8'h13));

    // R10 repeated start ends the write
    n0 = load_cnt;
    do_start(); dev_addr(0); send(8'h02); send(8'h44); do_start();
    check("R10 load on restart", 64'(load_cnt - n0), 1);
    check("R10 data", last_ld, put(snap, 2, 8'h44));

    // R12 read access
    n0 = load_cnt; reg_cnt = 0;
    dev_addr(1); send(8'h09); send(8'h0A); do_stop();
    check("R12 no load", 64'(load_cnt - n0), 0);
    check("R12 no reg write", 64'(reg_cnt), 0);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R11 watchdog actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule